// File: doc/BRIEF.md
# Phase-Accumulator Tick Generator

This block is a numerically controlled oscillator for one channel. It runs on a fixed reference clock. On every cycle it adds an increment to a 16-bit phase register. Its top bit is a square wave whose frequency is `inc * clk / 65536`. A one-cycle tick marks each rising edge of that wave, and a downstream pulse-width stage can use the tick as its time base.

The increment comes from a 16-bit control word, which is loaded as two bytes. If the word is below 0x8000, the increment is the word itself. Otherwise the increment is the 16-bit two's complement of the word, so 0x8000 maps to itself and 0xFFFF maps to 1.

A small load state machine prevents the oscillator from ever using a half-written word. It has two states:
- **LD_EMPTY**: no upper byte is waiting.
- **LD_HI_HELD**: an upper byte has been staged.

Its transitions are:
- **stage** (LD_EMPTY to LD_HI_HELD): an upper-byte write.
- **restage** (LD_HI_HELD to LD_HI_HELD): an upper-only write, which replaces the staged byte.
- **commit** (LD_HI_HELD to LD_EMPTY): a lower-byte write, which installs both halves.
- **direct commit** (LD_EMPTY to LD_EMPTY): upper and lower written in the same cycle.

A lower-only write in LD_EMPTY is ignored. A start pulse clears the phase so that the waveform's phase is known after enable.

Top module: `nco_gen`

## Requirements
- R1: While the synchronous reset `rst` is held, and after its release, the phase, the committed word (0) and the outputs start at zero. With word 0 the increment is 0, so `wave_o` and `tick_o` stay 0.
- R2: The increment equals the committed word when the word is below 0x8000. Otherwise it is (0x10000 - word) mod 0x10000, for example 0x8000 gives 0x8000, 0x8001 gives 0x7FFF and 0xFFFF gives 1.
- R3: On each clock edge without start, the phase advances by the increment modulo 2^16. `wave_o` is bit 15 of the phase register.
- R4: An upper-byte write stages `cw_hi_i` as bits 15:8. A later lower-byte write commits {staged, `cw_lo_i`} at that clock edge, and the phase uses the new increment from the next edge on.
- R5: A lower-byte write while no upper byte is staged (state LD_EMPTY) is ignored: the committed word does not change.
- R6: Upper and lower writes in the same cycle commit {`cw_hi_i`, `cw_lo_i`} at once.
- R7: Repeated upper writes before the lower write replace the staged byte; the last one is used.
- R8: `start_i` high at a clock edge sets the phase to 0 at that edge, so `wave_o` and `tick_o` are 0 in the following cycle.
- R9: `tick_o` is high for exactly the one cycle in which `wave_o` has just changed from 0 to 1, and at no other time.
- R10: For a word 2^k (k = 0..15), after a start the wave has period 2^(16-k) cycles with exactly half of them high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Channel start; clears the phase |
| cw_hi_we_i | input | 1 | Upper control-byte write strobe |
| cw_hi_i | input | 8 | Upper control byte (word bits 15:8) |
| cw_lo_we_i | input | 1 | Lower control-byte write strobe; commits the word |
| cw_lo_i | input | 8 | Lower control byte (word bits 7:0) |
| wave_o | output | 1 | Phase MSB square wave |
| tick_o | output | 1 | One-cycle pulse on each rising edge of `wave_o` |

## Verification
The hardest case to reach from the ports is a commit that lands while the phase is partway through a period. Here the old increment is applied at the commit edge itself, and the new one applies only from the following edge. The bench reaches this case by reloading words without a start between them, and it compares against an arithmetic phase model on every cycle. Slow words also take long to show a full period. So the exact half-high and one-tick counts are measured for words 2^4 to 2^15, and the smallest words are covered by cycle-by-cycle comparison over a shorter window.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Control-word load sequencer states
    typedef enum logic {
        LD_EMPTY   = 1'b0,
        LD_HI_HELD = 1'b1
    } ld_state_e;

endpackage

// File: rtl/nco_word_loader.sv
module nco_word_loader
    import nco_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] hi_d,
    input  logic              lo_we,
    input  logic [HALF_W-1:0] lo_d,
    output logic [WORD_W-1:0] word_o
);

    ld_state_e         state_q, state_d;
    logic [HALF_W-1:0] stage_q;
    logic [WORD_W-1:0] word_q;
    logic              commit;
    logic [HALF_W-1:0] commit_hi;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: stage, restage, commit, direct commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_EMPTY: begin
                if (hi_we && !lo_we) begin
                    state_d = LD_HI_HELD;      // stage
                end
            end
            LD_HI_HELD: begin
                if (lo_we) begin
                    state_d = LD_EMPTY;        // commit
                end
            end
            default: state_d = LD_EMPTY;
        endcase
    end

    // Output decisions
    always_comb begin
        commit    = 1'b0;
        commit_hi = stage_q;
        unique case (state_q)
            LD_EMPTY: begin
                commit    = lo_we && hi_we;    // direct commit only
                commit_hi = hi_d;
            end
            LD_HI_HELD: begin
                commit    = lo_we;
                commit_hi = hi_we ? hi_d : stage_q;
            end
            default: begin
                commit    = 1'b0;
                commit_hi = stage_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            word_q  <= '0;
        end else begin
            if (hi_we) begin
                stage_q <= hi_d;
            end
            if (commit) begin
                word_q <= {commit_hi, lo_d};
            end
        end
    end

    assign word_o = word_q;

    // R4: word changes only on a lower-byte write
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !lo_we |=> $stable(word_o));

    // R5: a lower-only write with nothing staged is ignored
    p_lo_alone_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == LD_EMPTY && lo_we && !hi_we) |=> $stable(word_o));

    // R6: simultaneous write installs both bytes
    p_direct_commit_r6: assert property (@(posedge clk) disable iff (rst)
        (hi_we && lo_we) |=> word_o == {$past(hi_d), $past(lo_d)});

endmodule

// File: rtl/nco_increment.sv
module nco_increment #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] inc_o
);

    localparam int MSB = WORD_W - 1;

    always_comb begin
        if (word_i[MSB]) begin
            inc_o = (~word_i) + {{(WORD_W-1){1'b0}}, 1'b1};
        end else begin
            inc_o = word_i;
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] inc_i,
    output logic              wave_o,
    output logic              tick_o
);

    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0] acc_q, acc_d;
    logic              tick_q;

    always_comb begin
        if (start_i) begin
            acc_d = '0;
        end else begin
            acc_d = acc_q + inc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= acc_d[MSB] & ~acc_q[MSB];
        end
    end

    assign wave_o = acc_q[MSB];
    assign tick_o = tick_q;

    // R2: increment never exceeds half the phase range
    p_inc_range_r2: assert property (@(posedge clk) disable iff (rst)
        inc_i[MSB] |-> (inc_i[MSB-1:0] == '0));

    // R3: phase advances by the increment each cycle
    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> acc_q == $past(acc_q) + $past(inc_i));

    // R8: start clears phase and outputs
    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (acc_q == '0 && !wave_o && !tick_o));

    // R9: tick only on a rising wave
    p_tick_edge_r9: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (wave_o && !$past(wave_o)));

    p_rise_ticks_r9: assert property (@(posedge clk) disable iff (rst)
        (wave_o && !$past(wave_o)) |-> tick_o);

endmodule

// File: rtl/nco_gen.sv
module nco_gen #(
    parameter int WORD_W = 16,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cw_hi_we_i,
    input  logic [HALF_W-1:0] cw_hi_i,
    input  logic              cw_lo_we_i,
    input  logic [HALF_W-1:0] cw_lo_i,
    output logic              wave_o,
    output logic              tick_o
);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] inc;

    nco_word_loader #(.HALF_W(HALF_W)) u_loader (
        .clk    (clk),
        .rst    (rst),
        .hi_we  (cw_hi_we_i),
        .hi_d   (cw_hi_i),
        .lo_we  (cw_lo_we_i),
        .lo_d   (cw_lo_i),
        .word_o (word)
    );

    nco_increment #(.WORD_W(WORD_W)) u_inc (
        .word_i (word),
        .inc_o  (inc)
    );

    nco_phase_acc #(.WORD_W(WORD_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .inc_i   (inc),
        .wave_o  (wave_o),
        .tick_o  (tick_o)
    );

    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!wave_o && !tick_o));

endmodule

// File: tb/test_nco_gen.sv
module test_nco_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       cw_hi_we_i = 1'b0;
    logic [7:0] cw_hi_i = '0;
    logic       cw_lo_we_i = 1'b0;
    logic [7:0] cw_lo_i = '0;
    logic       wave_o, tick_o;

    int errors = 0;
    int checks = 0;
    int hi_cnt = 0;
    int tk_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_gen i_nco_gen (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cw_hi_we_i(cw_hi_we_i), .cw_hi_i(cw_hi_i),
        .cw_lo_we_i(cw_lo_we_i), .cw_lo_i(cw_lo_i),
        .wave_o(wave_o), .tick_o(tick_o)
    );

    // Arithmetic reference from the requirements
    logic [15:0] acc_m = '0, cw_m = '0;
    logic [7:0]  stg_m = '0;
    logic        pend_m = 1'b0, tick_m = 1'b0;

    function automatic logic [15:0] inc_of(input logic [15:0] w);
        int v;
        if (w < 16'h8000) v = w;
        else v = (32'h10000 - w) % 32'h10000;
        return v[15:0];
    endfunction

    always @(posedge clk) begin
        logic [15:0] nxt;
        if (rst) begin
            acc_m <= '0; cw_m <= '0; stg_m <= '0; pend_m <= 1'b0; tick_m <= 1'b0;
        end else begin
            nxt = start_i ? 16'h0 : acc_m + inc_of(cw_m);
            tick_m <= nxt[15] & ~acc_m[15];
            acc_m  <= nxt;
            if (cw_lo_we_i && (cw_hi_we_i || pend_m))
                cw_m <= {cw_hi_we_i ? cw_hi_i : stg_m, cw_lo_i};
            if (cw_hi_we_i) stg_m <= cw_hi_i;
            pend_m <= cw_lo_we_i ? 1'b0 : (cw_hi_we_i ? 1'b1 : pend_m);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: wait for falling edge, compare every output to the model
    task automatic step();
        @(negedge clk);
        check("R3 wave", wave_o, acc_m[15]);
        check("R9 tick", tick_o, tick_m);
        if (wave_o) hi_cnt++;
        if (tick_o) tk_cnt++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] l);
        cw_hi_we_i = 1'b1; cw_hi_i = h;
        step();
        cw_hi_we_i = 1'b0; cw_lo_we_i = 1'b1; cw_lo_i = l;
        step();
        cw_lo_we_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        check("R8 start wave", wave_o, 0);
        check("R8 start tick", tick_o, 0);
        hi_cnt = 0; tk_cnt = 0;
    endtask

    initial begin
        logic [15:0] w;
        int p;
        run(3);
        check("R1 reset wave", wave_o, 0);
        check("R1 reset tick", tick_o, 0);
        rst = 1'b0;
        hi_cnt = 0; tk_cnt = 0;
        run(20);
        check("R1 idle highs", hi_cnt, 0);

        // R10: power-of-two sweep with period and duty measurement
        for (int k = 4; k <= 15; k++) begin
            w = 16'(1) << k;
            load(w[15:8], w[7:0]);
            do_start();
            p = 1 << (16 - k);
            run(p);
            check("R10 half high", hi_cnt, p / 2);
            check("R10 one tick", tk_cnt, 1);
            run(p);
            check("R10 two periods ticks", tk_cnt, 2);
        end
        for (int k = 0; k < 4; k++) begin
            w = 16'(1) << k;
            load(w[15:8], w[7:0]);
            do_start();
            run(2000);
        end

        // R2: complement mapping above 0x8000, mid-run reloads (R4)
        load(8'h00, 8'h03);   run(300);
        load(8'h7F, 8'hFF);   run(300);
        load(8'h80, 8'h01);   run(300);
        load(8'hC0, 8'h00);   run(300);
        load(8'hFF, 8'hF0);   run(300);
        load(8'hFF, 8'hFF);   run(300);
        // R2: 0xF000 -> inc 0x1000, period 16
        load(8'hF0, 8'h00);
        do_start(); run(64);
        check("R2 complement ticks", tk_cnt, 4);

        // R5: lower-only write while empty must not change period 16
        load(8'h10, 8'h00);
        cw_lo_we_i = 1'b1; cw_lo_i = 8'h55; step(); cw_lo_we_i = 1'b0;
        do_start(); run(64);
        check("R5 ignored lower", tk_cnt, 4);

        // R7: restage, last upper byte wins -> 0x0800, period 32
        cw_hi_we_i = 1'b1; cw_hi_i = 8'h40; step();
        cw_hi_i = 8'h08; step();
        cw_hi_we_i = 1'b0; cw_lo_we_i = 1'b1; cw_lo_i = 8'h00; step();
        cw_lo_we_i = 1'b0;
        do_start(); run(128);
        check("R7 last upper", tk_cnt, 4);

        // R6: simultaneous write -> 0x2000, period 8
        cw_hi_we_i = 1'b1; cw_hi_i = 8'h20; cw_lo_we_i = 1'b1; cw_lo_i = 8'h00;
        step();
        cw_hi_we_i = 1'b0; cw_lo_we_i = 1'b0;
        do_start(); run(64);
        check("R6 direct commit", tk_cnt, 8);

        // R8: start while wave is high
        run(5);
        check("R8 wave high before start", wave_o, 1);
        do_start();
        run(20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule